// File: doc/BRIEF.md
# DMA Bus Handoff Controller

This block decides who drives a single, non-multiplexed memory bus: the processor core or an external DMA master. The master asks for the bus by pulling an active-low request pin low and holding it there. The controller passes that pin through a synchroniser. It then waits until the core reports that no bus cycle is under way. At that point it stalls the core, turns off the core's address, data and control drivers, and pulls the active-low acknowledge low.

The master keeps the bus for as long as it holds its request low; there is no time limit. Once the request is released, the acknowledge goes high first. One cycle later the core drivers are enabled again and the stall is lifted. Because of this cycle, the two masters never drive the bus together. The drivers for each bus are switched as one group, because the address and data buses are separate.

Top module: `dma_handoff_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, `dma_ack_n` is 1, every bit of the three enable outputs is 1 and `core_stall` is 0.
- R2: The request passes through two flip-flops before use. With `core_bus_idle` held at 1, `dma_ack_n` goes to 0 on the third rising clock edge after `dma_req_n` is first sampled low, and not earlier.
- R3: A grant is made only on an edge where `core_bus_idle` is sampled 1. While the synchronised request is pending and the core is busy, `dma_ack_n` stays 1 and the enables stay 1. The grant happens on the first edge that samples the core idle.
- R4: While `dma_ack_n` is 0, `core_stall` is 1 and all enables are 0. In the cycle of a grant, all three outputs change together.
- R5: While `dma_req_n` stays low, the grant holds for any length of time, whatever `core_bus_idle` does.
- R6: Release timing. `dma_ack_n` returns to 1 on the third rising edge after `dma_req_n` is first sampled high. In that cycle the enables are still 0 and `core_stall` is still 1. On the next edge the enables return to all ones and `core_stall` returns to 0.
- R7: `dma_ack_n` is never 0 in a cycle where any enable bit is 1.
- R8: Each bus is released whole. All bits of `addr_oe`, `data_oe` and `ctrl_oe` carry one common value in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dma_req_n | input | 1 | Bus request from the DMA master, active low, asynchronous |
| core_bus_idle | input | 1 | Core reports that no bus cycle is in progress |
| dma_ack_n | output | 1 | Bus grant to the DMA master, active low |
| core_stall | output | 1 | Holds the core while it does not own the bus |
| addr_oe | output | ADDR_W (16) | Core address pin driver enables |
| data_oe | output | DATA_W (8) | Core data pin driver enables |
| ctrl_oe | output | CTRL_W (4) | Core control pin driver enables |

## Verification
A state register that is wrong shows up at the ports within one clock. The acknowledge, the stall and the enables are all decoded from one owner state. A stray value therefore either breaks their fixed relationship in that same cycle, or moves a grant or release edge away from the cycle the reference model predicts. A synchroniser with the wrong number of stages moves both handshake edges by whole cycles, so the first request shows it. A lost hand-back cycle shows as acknowledge and enables changing on the same edge at release.

// File: rtl/dh_pkg.sv
package dh_pkg;

    typedef enum logic [1:0] {
        OWN_CORE = 2'd0,
        OWN_DMA  = 2'd1,
        HANDBACK = 2'd2
    } owner_e;

    typedef struct packed {
        logic ack_n;
        logic drive;
        logic stall;
    } ctl_t;

    function automatic ctl_t ctl_of(owner_e s);
        ctl_t c;
        case (s)
            OWN_DMA:  begin c.ack_n = 1'b0; c.drive = 1'b0; c.stall = 1'b1; end
            HANDBACK: begin c.ack_n = 1'b1; c.drive = 1'b0; c.stall = 1'b1; end
            default:  begin c.ack_n = 1'b1; c.drive = 1'b1; c.stall = 1'b0; end
        endcase
        return c;
    endfunction

    function automatic owner_e next_owner(owner_e s, logic req, logic idle);
        owner_e n;
        n = s;
        case (s)
            OWN_CORE: if (req && idle) n = OWN_DMA;
            OWN_DMA:  if (!req)        n = HANDBACK;
            HANDBACK:                  n = OWN_CORE;
            default:                   n = OWN_CORE;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dh_sync.sv
module dh_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[LAST-1:0], d};
    end

    assign q = chain[LAST];
endmodule

// File: rtl/dh_fsm.sv
module dh_fsm
    import dh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic idle,
    output ctl_t ctl
);
    owner_e owner_q;

    always_ff @(posedge clk) begin
        if (rst) owner_q <= OWN_CORE;
        else     owner_q <= next_owner(owner_q, req, idle);
    end

    assign ctl = ctl_of(owner_q);
endmodule

// File: rtl/dh_fanout.sv
module dh_fanout #(
    parameter int W = 8
) (
    input  logic         en,
    output logic [W-1:0] oe
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign oe[i] = en;
    end
endmodule

// File: rtl/dma_handoff_ctrl.sv
module dma_handoff_ctrl
    import dh_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int CTRL_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_req_n,
    input  logic              core_bus_idle,
    output logic              dma_ack_n,
    output logic              core_stall,
    output logic [ADDR_W-1:0] addr_oe,
    output logic [DATA_W-1:0] data_oe,
    output logic [CTRL_W-1:0] ctrl_oe
);
    logic req_n_sync;
    ctl_t ctl;

    dh_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(dma_req_n), .q(req_n_sync)
    );

    dh_fsm u_fsm (
        .clk(clk), .rst(rst), .req(~req_n_sync), .idle(core_bus_idle), .ctl(ctl)
    );

    dh_fanout #(.W(ADDR_W)) u_addr (.en(ctl.drive), .oe(addr_oe));
    dh_fanout #(.W(DATA_W)) u_data (.en(ctl.drive), .oe(data_oe));
    dh_fanout #(.W(CTRL_W)) u_ctrl (.en(ctl.drive), .oe(ctrl_oe));

    assign dma_ack_n  = ctl.ack_n;
    assign core_stall = ctl.stall;
endmodule

// File: rtl/dma_handoff_chk.sv
module dma_handoff_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int CTRL_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              dma_req_n,
    input logic              core_bus_idle,
    input logic              dma_ack_n,
    input logic              core_stall,
    input logic [ADDR_W-1:0] addr_oe,
    input logic [DATA_W-1:0] data_oe,
    input logic [CTRL_W-1:0] ctrl_oe
);
    logic all_on, all_off;
    assign all_on  = (&addr_oe) && (&data_oe) && (&ctrl_oe);
    assign all_off = !(|addr_oe) && !(|data_oe) && !(|ctrl_oe);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dma_ack_n && all_on && !core_stall)); // R1
    AST_GRANT_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(dma_ack_n) |-> $past(core_bus_idle)); // R3
    AST_GRANT_STALLS: assert property (@(posedge clk) disable iff (rst)
        !dma_ack_n |-> (core_stall && all_off)); // R4
    AST_GRANT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!dma_ack_n && !dma_req_n && $past(!dma_req_n) && $past(!dma_req_n, 2)) |=> !dma_ack_n); // R5
    AST_HANDBACK_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_ack_n) |-> (all_off && core_stall)); // R6
    AST_HANDBACK_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_ack_n) |=> (all_on && !core_stall)); // R6
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !dma_ack_n |-> !(|addr_oe || |data_oe || |ctrl_oe)); // R7
    AST_WHOLE_BUS: assert property (@(posedge clk) disable iff (rst)
        (all_on || all_off)); // R8
endmodule

bind dma_handoff_ctrl dma_handoff_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)
) chk_i (
    .clk(clk), .rst(rst), .dma_req_n(dma_req_n), .core_bus_idle(core_bus_idle),
    .dma_ack_n(dma_ack_n), .core_stall(core_stall),
    .addr_oe(addr_oe), .data_oe(data_oe), .ctrl_oe(ctrl_oe)
);

// File: tb/dma_handoff_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_handoff_ctrl_tb_top;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dma_req_n = 1'b1;
    logic core_bus_idle = 1'b0;
    logic dma_ack_n, core_stall;
    logic [AW-1:0] addr_oe;
    logic [DW-1:0] data_oe;
    logic [CW-1:0] ctrl_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dma_handoff_ctrl dut_i (
        .clk(clk), .rst(rst), .dma_req_n(dma_req_n), .core_bus_idle(core_bus_idle),
        .dma_ack_n(dma_ack_n), .core_stall(core_stall),
        .addr_oe(addr_oe), .data_oe(data_oe), .ctrl_oe(ctrl_oe)
    );

    // Behavioural reference: the synchroniser is a queue of past request samples,
    // ownership is an integer (0 core, 1 DMA master, 2 hand-back cycle).
    bit req_hist[$] = '{1'b1, 1'b1};
    int mode = 0;

    always @(posedge clk) begin
        if (rst) begin
            req_hist = '{1'b1, 1'b1};
            mode = 0;
        end else begin
            bit seen_n;
            seen_n = req_hist[0];
            if (mode == 0 && !seen_n && core_bus_idle) mode = 1;
            else if (mode == 1 && seen_n)              mode = 2;
            else if (mode == 2)                        mode = 0;
            void'(req_hist.pop_front());
            req_hist.push_back(dma_req_n);
        end
    end

    task automatic check(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2 ack vs model", dma_ack_n, (mode != 1));
            check("R4 stall vs model", core_stall, (mode != 0));
            check("R8 addr_oe vs model", addr_oe, (mode == 0) ? {AW{1'b1}} : '0);
            check("R8 data_oe vs model", data_oe, (mode == 0) ? {DW{1'b1}} : '0);
            check("R8 ctrl_oe vs model", ctrl_oe, (mode == 0) ? {CW{1'b1}} : '0);
            if (!dma_ack_n) check("R7 enables off under grant", {addr_oe, data_oe, ctrl_oe}, 0);
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic summary();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired at %0t", $time);
        summary();
    end

    initial begin
        @(negedge clk);
        check("R1 ack in reset", dma_ack_n, 1);
        step(3);
        rst = 1'b0;
        step(1);
        check("R1 ack after reset", dma_ack_n, 1);
        check("R1 addr_oe after reset", addr_oe, {AW{1'b1}});
        check("R1 stall after reset", core_stall, 0);

        // R2: latency of the grant through the synchroniser
        core_bus_idle = 1'b1;
        dma_req_n = 1'b0;
        step(2);
        check("R2 no grant after two edges", dma_ack_n, 1);
        step(1);
        check("R2 grant on third edge", dma_ack_n, 0);
        check("R4 stall at grant", core_stall, 1);
        check("R4 data_oe off at grant", data_oe, 0);

        // R5: long hold with the idle input wandering
        for (int i = 0; i < 500; i++) begin
            core_bus_idle = i[0];
            step(1);
        end
        check("R5 grant still held", dma_ack_n, 0);

        // R6: release sequence
        dma_req_n = 1'b1;
        step(2);
        check("R6 ack held two edges after release", dma_ack_n, 0);
        step(1);
        check("R6 ack high on third edge", dma_ack_n, 1);
        check("R6 enables still off", ctrl_oe, 0);
        check("R6 stall still on", core_stall, 1);
        step(1);
        check("R6 enables back", ctrl_oe, {CW{1'b1}});
        check("R6 stall removed", core_stall, 0);

        // R3: busy core delays the grant
        core_bus_idle = 1'b0;
        dma_req_n = 1'b0;
        step(10);
        check("R3 no grant while busy", dma_ack_n, 1);
        check("R3 core keeps bus while busy", addr_oe, {AW{1'b1}});
        core_bus_idle = 1'b1;
        step(1);
        check("R3 grant on first idle edge", dma_ack_n, 0);
        dma_req_n = 1'b1;
        step(5);
        check("R3 bus back to core", dma_ack_n, 1);

        // Mixed traffic: long and short requests, random idle
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 7) == 0) dma_req_n = ~dma_req_n;
            core_bus_idle = 1'($urandom_range(0, 1));
            step(1);
        end
        dma_req_n = 1'b1;
        step(6);
        check("R1 quiet end state", dma_ack_n, 1);
        summary();
    end
endmodule